// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is meant for this station by looking at its 48-bit destination address. A start strobe hands it the address together with a 2-bit hash window selector. It first walks a table of exact-match address entries, one per clock. Any entry whose valid flag is clear is skipped. If an enabled entry equals the address, the frame is accepted at once. If none matches, the block derives a 12-bit hash from the last two address bytes. That hash picks one bit of a 4096-bit multicast table, and a set bit accepts the frame.

Each lookup ends with a one-cycle done pulse. The verdict and the kind of match are held on the outputs until the next lookup finishes. Every accept made through the multicast table also advances a saturating counter. Both tables are loaded through simple address/data/write-enable ports, and those ports may be used at any time, including while a scan is running.

Top module: `rx_da_filter`

## Requirements
- R1: Reset clears every valid flag, the multicast-hit counter, `done`, `accept`, `busy` and `match_type`. An address programmed before a reset is not matched exactly after it.
- R2: An exact entry is two 32-bit words written through `ra_addr` (bit 0 = 0 for the low word, 1 for the high word; bits above select the entry). Address byte n lies in `dest_addr[8n+7:8n]`. Bytes 0 to 3 are held in the low word with byte 0 in bits 7:0. Bytes 4 and 5 are held in bits 15:0 of the high word, and bit 31 of the high word is the valid flag.
- R3: An entry whose valid flag is clear never produces a match, whatever address it holds.
- R4: A hit on valid entry k gives `accept`=1 and `match_type`=1 (exact). `done` rises k+1 clocks after the clock edge that samples `start`. The multicast table is not consulted and the counter is unchanged.
- R5: The 16-bit hash source is {byte 5, byte 4}. It is shifted right by 4, 3, 2 or 0 bits for `mc_offset` codes 0, 1, 2 and 3, and the result is truncated to 12 bits.
- R6: When no exact entry matches, hash bits 11:5 select a multicast word and bits 4:0 select a bit within it. A set bit gives `accept`=1 and `match_type`=2 (hash). A clear bit gives `accept`=0 and `match_type`=0. `done` rises N_ENTRIES+1 clocks after the start edge.
- R7: Each multicast accept adds one to `mc_hit_count`, which stops at all ones instead of wrapping.
- R8: `done` is high for exactly one cycle per lookup. `accept` and `match_type` hold their values until the next `done`.
- R9: `start` is ignored while `busy` is high. A `start` in the cycle where `done` is high begins a new lookup.
- R10: A table write takes effect at the clock edge that samples it. An entry written during a scan is matched if the scan has not yet reached it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (ignored while busy) |
| dest_addr | input | 48 | Destination address, byte n in bits 8n+7:8n |
| mc_offset | input | 2 | Hash window selector |
| ra_we | input | 1 | Exact-table write enable |
| ra_addr | input | $clog2(N_ENTRIES)+1 | Entry index and low/high word select |
| ra_wdata | input | 32 | Exact-table write data |
| mta_we | input | 1 | Multicast-table write enable |
| mta_addr | input | 7 | Multicast-table word index |
| mta_wdata | input | 32 | Multicast-table write data |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| accept | output | 1 | Frame accepted |
| match_type | output | 2 | 0 none, 1 exact, 2 hash |
| mc_hit_count | output | CNT_W | Saturating multicast-accept counter |

## Verification
Two activities can land in the same cycle. The first pair is a table write and the scan step that compares the same or a later entry. The bench provokes this by programming an entry while a scan is in progress and expects an exact hit at that entry's own latency. The second pair is a new `start` and the `done` pulse of the previous lookup. The bench raises `start` in the done cycle and requires a second complete lookup, while a `start` sent mid-scan must leave the first result and its timing untouched. A behavioural model that applies writes after that cycle's compare judges every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_W    = 48;
    localparam int REG_W     = 32;
    localparam int HASH_W    = 12;
    localparam int BIT_SEL_W = $clog2(REG_W);
    localparam int WORD_SEL_W = HASH_W - BIT_SEL_W;
    localparam int MTA_WORDS = 1 << WORD_SEL_W;
    localparam int VALID_BIT = 31;

    typedef enum logic [1:0] {
        MT_NONE  = 2'd0,
        MT_EXACT = 2'd1,
        MT_HASH  = 2'd2
    } match_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HASH = 2'd2
    } state_t;

    typedef struct packed {
        logic [WORD_SEL_W-1:0] word;
        logic [BIT_SEL_W-1:0]  bitsel;
    } hash_t;

    // Select a 12-bit window of {byte5, byte4}
    function automatic hash_t hash_window(input logic [ADDR_W-1:0] a,
                                          input logic [1:0] code);
        logic [15:0] src;
        logic [15:0] sh;
        src = a[47:32];
        case (code)
            2'd0:    sh = src >> 4;
            2'd1:    sh = src >> 3;
            2'd2:    sh = src >> 2;
            default: sh = src;
        endcase
        return hash_t'(sh[HASH_W-1:0]);
    endfunction

endpackage

// File: rtl/rxf_exact_table.sv
module rxf_exact_table
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W:0]    waddr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [REG_W-1:0] lo_q [N_ENTRIES];
    logic [REG_W-1:0] hi_q [N_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else if (we) begin
            if (waddr[0])
                hi_q[waddr[IDX_W:1]] <= wdata;
            else
                lo_q[waddr[IDX_W:1]] <= wdata;
        end
    end

    logic [REG_W-1:0] sel_lo, sel_hi;
    assign sel_lo = lo_q[sel_idx];
    assign sel_hi = hi_q[sel_idx];
    assign hit    = sel_hi[VALID_BIT] && ({sel_hi[15:0], sel_lo} == addr);

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
    import rxf_pkg::*;
(
    input  logic                  clk,
    input  logic                  we,
    input  logic [WORD_SEL_W-1:0] waddr,
    input  logic [REG_W-1:0]      wdata,
    input  hash_t                 lookup,
    output logic                  hit
);

    logic [REG_W-1:0] mem [MTA_WORDS];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    logic [REG_W-1:0] word_sel;
    assign word_sel = mem[lookup.word];
    assign hit      = word_sel[lookup.bitsel];

endmodule

// File: rtl/rxf_sat_counter.sv
module rxf_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] MAX_VAL = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != MAX_VAL)
            count <= count + 1'b1;
    end

    // R7: saturation holds
    p_hold_at_max_r7: assert property (@(posedge clk) disable iff (rst)
        (count == MAX_VAL) |=> (count == MAX_VAL));

    // R7: never moves by more than one step upward
    p_single_step_r7: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + 1'b1));

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [47:0]           dest_addr,
    input  logic [1:0]            mc_offset,
    input  logic                  ra_we,
    input  logic [IDX_W:0]        ra_addr,
    input  logic [31:0]           ra_wdata,
    input  logic                  mta_we,
    input  logic [6:0]            mta_addr,
    input  logic [31:0]           mta_wdata,
    output logic                  busy,
    output logic                  done,
    output logic                  accept,
    output logic [1:0]            match_type,
    output logic [CNT_W-1:0]      mc_hit_count
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    state_t            state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        off_q;
    match_t            mtype_q;
    logic              exact_hit;
    logic              mta_hit;
    hash_t             hsel;

    assign hsel = hash_window(addr_q, off_q);

    rxf_exact_table #(.N_ENTRIES(N_ENTRIES)) u_exact (
        .clk     (clk),
        .rst     (rst),
        .we      (ra_we),
        .waddr   (ra_addr),
        .wdata   (ra_wdata),
        .sel_idx (idx_q),
        .addr    (addr_q),
        .hit     (exact_hit)
    );

    rxf_hash_table u_hash (
        .clk    (clk),
        .we     (mta_we),
        .waddr  (mta_addr),
        .wdata  (mta_wdata),
        .lookup (hsel),
        .hit    (mta_hit)
    );

    rxf_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (state_q == ST_HASH && mta_hit),
        .count (mc_hit_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            addr_q  <= '0;
            off_q   <= '0;
            done    <= 1'b0;
            accept  <= 1'b0;
            mtype_q <= MT_NONE;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= dest_addr;
                        off_q   <= mc_offset;
                        idx_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (exact_hit) begin
                        done    <= 1'b1;
                        accept  <= 1'b1;
                        mtype_q <= MT_EXACT;
                        state_q <= ST_IDLE;
                    end else if (idx_q == LAST_IDX) begin
                        state_q <= ST_HASH;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_HASH: begin
                    done    <= 1'b1;
                    accept  <= mta_hit;
                    mtype_q <= mta_hit ? MT_HASH : MT_NONE;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign match_type = mtype_q;

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: verdict and match kind agree whenever a result is published
    p_accept_kind_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (accept == (match_type != 2'(MT_NONE))));

    // R4: an exact hit leaves the multicast counter alone
    p_exact_no_count_r4: assert property (@(posedge clk) disable iff (rst)
        (done && match_type == 2'(MT_EXACT)) |-> (mc_hit_count == $past(mc_hit_count)));

    // R9: a start during a lookup does not disturb the captured address
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (addr_q == $past(addr_q)));

endmodule

// File: tb/rx_da_filter_tb_top.sv
module rx_da_filter_tb_top;

    localparam int NE   = 16;
    localparam int CW   = 3;
    localparam int IW   = $clog2(NE);
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [47:0]   dest_addr = '0;
    logic [1:0]    mc_offset = '0;
    logic          ra_we = 1'b0;
    logic [IW:0]   ra_addr = '0;
    logic [31:0]   ra_wdata = '0;
    logic          mta_we = 1'b0;
    logic [6:0]    mta_addr = '0;
    logic [31:0]   mta_wdata = '0;
    logic          busy, done, accept;
    logic [1:0]    match_type;
    logic [CW-1:0] mc_hit_count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rx_da_filter #(.N_ENTRIES(NE), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .dest_addr(dest_addr),
        .mc_offset(mc_offset), .ra_we(ra_we), .ra_addr(ra_addr),
        .ra_wdata(ra_wdata), .mta_we(mta_we), .mta_addr(mta_addr),
        .mta_wdata(mta_wdata), .busy(busy), .done(done), .accept(accept),
        .match_type(match_type), .mc_hit_count(mc_hit_count)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_lo [NE];
    logic [31:0] m_hi [NE];
    logic [31:0] m_mta [128];
    int          m_state = 0;
    int          m_idx = 0;
    logic [47:0] m_addr = '0;
    logic [1:0]  m_off = '0;
    logic        m_done = 0, m_acc = 0;
    logic [1:0]  m_type = 0;
    int          m_cnt = 0;

    initial for (int i = 0; i < 128; i++) m_mta[i] = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NE; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
            m_state = 0; m_done = 0; m_acc = 0; m_type = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_state == 0) begin
                if (start) begin
                    m_addr = dest_addr; m_off = mc_offset; m_idx = 0; m_state = 1;
                end
            end else if (m_state == 1) begin
                if (m_hi[m_idx][31] && m_hi[m_idx][15:0] == m_addr[47:32]
                    && m_lo[m_idx] == m_addr[31:0]) begin
                    m_done = 1; m_acc = 1; m_type = 1; m_state = 0;
                end else if (m_idx == NE - 1) m_state = 2;
                else m_idx = m_idx + 1;
            end else begin
                int sh;
                int h;
                sh = (m_off == 0) ? 4 : (m_off == 1) ? 3 : (m_off == 2) ? 2 : 0;
                h  = (int'(m_addr[47:32]) >> sh) % 4096;
                m_done = 1;
                m_acc  = m_mta[h / 32][h % 32];
                m_type = m_acc ? 2'd2 : 2'd0;
                if (m_acc && m_cnt < int'(CMAX)) m_cnt = m_cnt + 1;
                m_state = 0;
            end
            if (ra_we) begin
                if (ra_addr[0]) m_hi[ra_addr[IW:1]] = ra_wdata;
                else            m_lo[ra_addr[IW:1]] = ra_wdata;
            end
        end
        if (mta_we) m_mta[mta_addr] = mta_wdata;
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R9", "busy", busy, m_state != 0);
            chk("R8", "done", done, m_done);
            chk("R6", "accept", accept, m_acc);
            chk("R4", "match_type", match_type, m_type);
            chk("R7", "count", mc_hit_count, m_cnt);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_ra(input int ent, input logic [47:0] a, input logic vld);
        @(negedge clk);
        ra_we = 1; ra_addr = {IW'(ent), 1'b0}; ra_wdata = a[31:0];
        @(negedge clk);
        ra_addr = {IW'(ent), 1'b1}; ra_wdata = {vld, 15'd0, a[47:32]};
        @(negedge clk);
        ra_we = 0;
    endtask

    task automatic wr_mta(input int w, input logic [31:0] d);
        @(negedge clk);
        mta_we = 1; mta_addr = 7'(w); mta_wdata = d;
        @(negedge clk);
        mta_we = 0;
    endtask

    task automatic wait_done(output logic acc, output logic [1:0] ty, inout int lat);
        while (!done) begin @(negedge clk); lat++; end
        acc = accept; ty = match_type;
    endtask

    task automatic lookup(input logic [47:0] a, input logic [1:0] off,
                          output logic acc, output logic [1:0] ty, output int lat);
        @(negedge clk);
        dest_addr = a; mc_offset = off; start = 1;
        @(negedge clk);
        start = 0; lat = 0;
        wait_done(acc, ty, lat);
    endtask

    localparam logic [47:0] ADDR_A = 48'h6655_4433_2211;
    localparam logic [47:0] ADDR_B = 48'h0605_0403_0201;
    localparam logic [47:0] ADDR_C = 48'h2A2B_2C2D_2E2F;
    localparam logic [47:0] ADDR_D = 48'hABCD_0000_1001;
    localparam logic [47:0] ADDR_E = 48'h7777_1234_5678;
    localparam logic [47:0] ADDR_M = 48'h0F0F_0000_0042;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic       acc;
        logic [1:0] ty;
        int         lat;
        int         exp_cnt;
        exp_cnt = 0;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset done", done, 0);
        chk("R1", "reset accept", accept, 0);
        chk("R1", "reset type", match_type, 0);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset count", mc_hit_count, 0);

        for (int w = 0; w < 128; w++) wr_mta(w, 32'd0);

        // R2 / R4: exact hit on entry 5, latency 6
        wr_ra(5, ADDR_A, 1'b1);
        lookup(ADDR_A, 2'd0, acc, ty, lat);
        chk("R4", "exact accept", acc, 1);
        chk("R4", "exact type", ty, 1);
        chk("R4", "exact latency", lat, 6);
        chk("R4", "exact count", mc_hit_count, 0);
        @(negedge clk);
        // R8: pulse ends, result held
        chk("R8", "done drop", done, 0);
        chk("R8", "accept held", accept, 1);

        // R2: byte order
        wr_ra(2, ADDR_B, 1'b1);
        lookup(48'h0102_0304_0506, 2'd0, acc, ty, lat);
        chk("R2", "reversed bytes reject", acc, 0);
        chk("R2", "reversed latency", lat, NE + 1);
        lookup(ADDR_B, 2'd0, acc, ty, lat);
        chk("R2", "packed match", ty, 1);
        chk("R2", "packed latency", lat, 3);

        // R3: invalid entry skipped
        wr_ra(7, ADDR_C, 1'b0);
        lookup(ADDR_C, 2'd2, acc, ty, lat);
        chk("R3", "invalid accept", acc, 0);
        chk("R3", "invalid type", ty, 0);

        // R5 / R6: hash windows of 0xABCD
        wr_mta(85, 32'h1000_0000);              // code 0 -> word 85 bit 28
        lookup(ADDR_D, 2'd0, acc, ty, lat);
        exp_cnt++;
        chk("R5", "code0 accept", acc, 1);
        chk("R6", "code0 type", ty, 2);
        chk("R6", "hash latency", lat, NE + 1);
        chk("R7", "count after hit", mc_hit_count, exp_cnt);
        lookup(ADDR_D, 2'd1, acc, ty, lat);     // word 43 bit 25
        chk("R5", "code1 reject", acc, 0);
        lookup(ADDR_D, 2'd2, acc, ty, lat);     // word 87 bit 19
        chk("R5", "code2 reject", acc, 0);
        lookup(ADDR_D, 2'd3, acc, ty, lat);     // word 94 bit 13
        chk("R5", "code3 reject", acc, 0);
        wr_mta(94, 32'h0000_2000);
        lookup(ADDR_D, 2'd3, acc, ty, lat);
        exp_cnt++;
        chk("R5", "code3 accept", acc, 1);
        wr_mta(43, 32'hFDFF_FFFF);              // every bit except 25
        lookup(ADDR_D, 2'd1, acc, ty, lat);
        chk("R6", "neighbour bits reject", acc, 0);

        // R4: exact wins even if the hash bit is set
        wr_mta(int'(ADDR_A[47:32] >> 4) / 32, 32'hFFFF_FFFF);
        lookup(ADDR_A, 2'd0, acc, ty, lat);
        chk("R4", "exact priority type", ty, 1);
        chk("R4", "exact priority count", mc_hit_count, exp_cnt);

        // R7: saturation
        for (int i = 0; i < 8; i++) begin
            lookup(ADDR_D, 2'd0, acc, ty, lat);
            if (exp_cnt < int'(CMAX)) exp_cnt++;
        end
        chk("R7", "saturated count", mc_hit_count, CMAX);

        // R9: start while busy ignored, start in done cycle accepted
        @(negedge clk);
        dest_addr = ADDR_M; mc_offset = 2'd3; start = 1;
        @(negedge clk);
        start = 0; lat = 0;
        repeat (3) begin @(negedge clk); lat++; end
        dest_addr = ADDR_A; start = 1;
        @(negedge clk); lat++;
        start = 0;
        wait_done(acc, ty, lat);
        chk("R9", "busy start ignored", ty, 0);
        chk("R9", "busy start latency", lat, NE + 1);
        dest_addr = ADDR_A; start = 1;
        @(negedge clk);
        start = 0; lat = 0;
        wait_done(acc, ty, lat);
        chk("R9", "done-cycle start", ty, 1);
        chk("R9", "done-cycle latency", lat, 6);

        // R10: write an entry ahead of the scan
        @(negedge clk);
        dest_addr = ADDR_E; mc_offset = 2'd3; start = 1;
        @(negedge clk);
        start = 0; lat = 0;
        ra_we = 1; ra_addr = {IW'(10), 1'b0}; ra_wdata = ADDR_E[31:0];
        @(negedge clk); lat++;
        ra_addr = {IW'(10), 1'b1}; ra_wdata = {1'b1, 15'd0, ADDR_E[47:32]};
        @(negedge clk); lat++;
        ra_we = 0;
        wait_done(acc, ty, lat);
        chk("R10", "mid-scan entry", ty, 1);
        chk("R10", "mid-scan latency", lat, 11);

        // R1: reset clears valid flags
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        chk("R1", "count cleared", mc_hit_count, 0);
        wr_mta(int'(ADDR_A[47:32] >> 4) / 32, 32'd0);
        lookup(ADDR_A, 2'd0, acc, ty, lat);
        chk("R1", "valid cleared", acc, 0);
        chk("R1", "valid cleared type", ty, 0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule